// File: doc/BRIEF.md
# Daisy-Chain Serial Configuration Receiver

This block is the serial front end of one device in a chain of devices that receive configuration data over the same link. It samples a bitstream on `din` at each rising edge of the external configuration clock `cclk`. While it searches for a fixed start pattern, every sampled bit is echoed on `dout` for the next device in the chain. After the pattern it reads a length field. This field gives the number of bits that follow it, and the block echoes the field as well. The block then takes in its own fixed-size frames and hands each one to a configuration memory port as a single-cycle write.

While its own frames arrive, `dout` stays high. A downstream device therefore never sees a frame start pair that is not meant for it. Once the local memory is full, further bits are echoed again. Counting stops when the number of bits received after the length field equals the length value. At that point the block raises done, drives `dout` high and ignores the link until `prog_n` is pulsed low again. Outgoing bits change on the falling edge of `cclk`, half a cycle after they were sampled.

Top module: `cfg_chain_rx`

## Requirements
- R1: `din` is sampled on the rising edge of `cclk`, and `dout` changes only on a falling edge. The value `dout` takes at a falling edge comes from the bit sampled at the rising edge just before it.
- R2: While `prog_n` is low, `dout` is 1 and `cfg_done`, `cfg_err` and `frm_we` are 0. After release the block searches for the start pattern again, and the first sample is taken on the third rising edge after release.
- R3: During the search, every sampled bit is echoed on `dout`. The search ends on the bit that completes the `PRE_W`-bit pattern `PRE_VAL`, where the earliest bit received is the pattern MSB. No bits are counted during the search.
- R4: The `LEN_W` bits right after the pattern form the length value, sent MSB first. Each of these bits is echoed on `dout`.
- R5: While the block takes in its own frame bits, `dout` is 1.
- R6: A frame is `FRAME_W` bits long: a start bit 0, then a 1, then `FRAME_W-2` payload bits sent MSB first. `frm_we` is 1 for exactly one cycle, starting at the rising edge that samples the last bit of the frame. During that cycle `frm_data` holds the payload and `frm_addr` holds the frame index, which counts 0, 1, 2 and so on.
- R7: If a frame's first two bits are not 0 then 1, `cfg_err` becomes 1 and stays 1 until reset. The frame is still written.
- R8: After `NUM_FRAMES` frames have been written, each further counted bit is echoed on `dout`.
- R9: Bits after the length field are counted. `cfg_done` rises at the rising edge that samples the bit bringing the count up to the length value, and any frame still incomplete at that point is dropped. A length of 0 raises `cfg_done` on the last bit of the length field.
- R10: Once `cfg_done` is 1, `dout` is 1 from the next falling edge on. After that there are no writes, and a new start pattern is ignored until reset.
- R11: `frm_we` is never high for two cycles in a row, and `frm_addr` is below `NUM_FRAMES` whenever `frm_we` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cclk | input | 1 | Configuration clock |
| prog_n | input | 1 | Active-low program/reset, asserted asynchronously and released synchronously |
| din | input | 1 | Serial bitstream in |
| dout | output | 1 | Serial bitstream toward the next device, changes on the falling edge |
| frm_we | output | 1 | One-cycle frame write strobe |
| frm_addr | output | ADDR_W | Index of the frame being written |
| frm_data | output | FRAME_W-2 | Frame payload |
| cfg_done | output | 1 | Length reached, block finished |
| cfg_err | output | 1 | Sticky bad start pair flag |

## Verification
The hardest situations to reach from the ports are the ones where the length value ends the stream at an exact boundary. One is a length that ends inside the block's own frames. Another ends exactly on the last frame bit, so the final write and done fall on the same edge. A third ends after the overflow bits, and a length of zero ends right after the length field. The bench builds each stream arithmetically from the length value, the index of a deliberately broken start pair and a payload seed. It sweeps the length across these boundaries, and for every bit it predicts `dout`, the write strobe and done. After done, each run sends a fresh start pattern, which must have no effect.

// File: rtl/cfg_rx_pkg.sv
package cfg_rx_pkg;
  typedef enum logic [2:0] {
    ST_HUNT = 3'd0,
    ST_LEN  = 3'd1,
    ST_FRM  = 3'd2,
    ST_PASS = 3'd3,
    ST_DONE = 3'd4
  } rx_state_e;
endpackage

// File: rtl/cfg_hdr_rx.sv
// Start pattern search window and length field capture.
module cfg_hdr_rx #(
  parameter int               PRE_W   = 8,
  parameter logic [PRE_W-1:0] PRE_VAL = 8'hB2,
  parameter int               LEN_W   = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic             hunt_en,
  input  logic             len_en,
  output logic             pre_hit,
  output logic             len_last,
  output logic [LEN_W-1:0] len_next,
  output logic [LEN_W-1:0] len_val
);
  localparam int LC_W = $clog2(LEN_W);

  logic [PRE_W-1:0] win_q, win_d, win_shift;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LC_W-1:0]  lc_q, lc_d;

  always_comb begin
    win_shift = {win_q[PRE_W-2:0], din};
    len_next  = {len_q[LEN_W-2:0], din};
    pre_hit   = hunt_en && (win_shift == PRE_VAL);
    len_last  = len_en && (lc_q == LC_W'(LEN_W - 1));
    win_d     = hunt_en ? win_shift : win_q;
    len_d     = len_en ? len_next : len_q;
    lc_d      = len_en ? lc_q + 1'b1 : lc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      len_q <= '0;
      lc_q  <= '0;
    end else begin
      win_q <= win_d;
      len_q <= len_d;
      lc_q  <= lc_d;
    end
  end

  assign len_val = len_q;
endmodule

// File: rtl/cfg_frame_asm.sv
// Local frame assembly: start pair check, payload shift, write port.
module cfg_frame_asm #(
  parameter int FRAME_W    = 6,
  parameter int NUM_FRAMES = 3,
  parameter int ADDR_W     = 2,
  parameter int PAY_W      = FRAME_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic              bit_en,
  output logic              mem_full_evt,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [PAY_W-1:0]  data,
  output logic              err
);
  localparam int FB_W = $clog2(FRAME_W);

  logic [FB_W-1:0]   fb_q, fb_d;
  logic [ADDR_W-1:0] fi_q, fi_d, addr_q, addr_d;
  logic [PAY_W-1:0]  pay_q, pay_d, pay_sh, data_q, data_d;
  logic              s0_q, s0_d, we_q, we_d, err_q, err_d;
  logic              last_bit;

  always_comb begin
    last_bit     = bit_en && (fb_q == FB_W'(FRAME_W - 1));
    mem_full_evt = last_bit && (fi_q == ADDR_W'(NUM_FRAMES - 1));
    pay_sh       = PAY_W'({pay_q, din});
    fb_d   = fb_q;
    fi_d   = fi_q;
    pay_d  = pay_q;
    s0_d   = s0_q;
    err_d  = err_q;
    we_d   = 1'b0;
    addr_d = addr_q;
    data_d = data_q;
    if (bit_en) begin
      fb_d = last_bit ? '0 : fb_q + 1'b1;
      if (fb_q == FB_W'(0)) s0_d = din;
      if ((fb_q == FB_W'(1)) && (s0_q || !din)) err_d = 1'b1;
      if (fb_q >= FB_W'(2)) pay_d = pay_sh;
    end
    if (last_bit) begin
      we_d   = 1'b1;
      addr_d = fi_q;
      data_d = pay_sh;
      fi_d   = fi_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_q   <= '0;
      fi_q   <= '0;
      pay_q  <= '0;
      s0_q   <= 1'b0;
      err_q  <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      fb_q   <= fb_d;
      fi_q   <= fi_d;
      pay_q  <= pay_d;
      s0_q   <= s0_d;
      err_q  <= err_d;
      we_q   <= we_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign we   = we_q;
  assign addr = addr_q;
  assign data = data_q;
  assign err  = err_q;
endmodule

// File: rtl/cfg_dout_retime.sv
// Falling-edge output stage: forwarded bit or idle high.
module cfg_dout_retime (
  input  logic clk,
  input  logic rst_n,
  input  logic fwd,
  input  logic bit_in,
  output logic dout
);
  logic out_q, out_d;

  always_comb out_d = fwd ? bit_in : 1'b1;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b1;
    else        out_q <= out_d;
  end

  assign dout = out_q;
endmodule

// File: rtl/cfg_chain_rx.sv
module cfg_chain_rx
  import cfg_rx_pkg::*;
#(
  parameter int               PRE_W      = 8,
  parameter logic [PRE_W-1:0] PRE_VAL    = 8'hB2,
  parameter int               LEN_W      = 24,
  parameter int               FRAME_W    = 6,
  parameter int               NUM_FRAMES = 3,
  parameter int               ADDR_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  parameter int               PAY_W      = FRAME_W - 2
) (
  input  logic              cclk,
  input  logic              prog_n,
  input  logic              din,
  output logic              dout,
  output logic              frm_we,
  output logic [ADDR_W-1:0] frm_addr,
  output logic [PAY_W-1:0]  frm_data,
  output logic              cfg_done,
  output logic              cfg_err
);
  // reset release synchronizer
  logic [1:0] rs_q;
  logic       rst_n;

  always_ff @(posedge cclk or negedge prog_n) begin
    if (!prog_n) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  rx_state_e        st_q, st_d;
  logic [LEN_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             fwd_q, fwd_d, bit_q;
  logic             hunt_en, len_en, frm_en, count_en, hit_len;
  logic             pre_hit, len_last, mem_full_evt;
  logic [LEN_W-1:0] len_next, len_val;

  cfg_hdr_rx #(.PRE_W(PRE_W), .PRE_VAL(PRE_VAL), .LEN_W(LEN_W)) u_hdr (
    .clk(cclk), .rst_n(rst_n), .din(din),
    .hunt_en(hunt_en), .len_en(len_en),
    .pre_hit(pre_hit), .len_last(len_last),
    .len_next(len_next), .len_val(len_val)
  );

  cfg_frame_asm #(.FRAME_W(FRAME_W), .NUM_FRAMES(NUM_FRAMES),
                  .ADDR_W(ADDR_W), .PAY_W(PAY_W)) u_frm (
    .clk(cclk), .rst_n(rst_n), .din(din), .bit_en(frm_en),
    .mem_full_evt(mem_full_evt), .we(frm_we), .addr(frm_addr),
    .data(frm_data), .err(cfg_err)
  );

  cfg_dout_retime u_out (
    .clk(cclk), .rst_n(rst_n), .fwd(fwd_q), .bit_in(bit_q), .dout(dout)
  );

  always_comb begin
    hunt_en  = (st_q == ST_HUNT);
    len_en   = (st_q == ST_LEN);
    frm_en   = (st_q == ST_FRM);
    count_en = frm_en || (st_q == ST_PASS);
    cnt_inc  = cnt_q + 1'b1;
    hit_len  = count_en && (cnt_inc == len_val);
    cnt_d    = count_en ? cnt_inc : cnt_q;
    fwd_d    = hunt_en || len_en || (st_q == ST_PASS);
    st_d     = st_q;
    unique case (st_q)
      ST_HUNT: if (pre_hit) st_d = ST_LEN;
      ST_LEN:  if (len_last) st_d = (len_next == '0) ? ST_DONE : ST_FRM;
      ST_FRM: begin
        if (hit_len)           st_d = ST_DONE;
        else if (mem_full_evt) st_d = ST_PASS;
      end
      ST_PASS: if (hit_len) st_d = ST_DONE;
      default: st_d = ST_DONE;
    endcase
  end

  always_ff @(posedge cclk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_HUNT;
      cnt_q <= '0;
      fwd_q <= 1'b0;
      bit_q <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      fwd_q <= fwd_d;
      bit_q <= din;
    end
  end

  assign cfg_done = (st_q == ST_DONE);
endmodule

// File: rtl/cfg_chain_rx_chk.sv
module cfg_chain_rx_chk #(
  parameter int ADDR_W     = 2,
  parameter int NUM_FRAMES = 3
) (
  input logic              cclk,
  input logic              prog_n,
  input logic              dout,
  input logic              frm_we,
  input logic [ADDR_W-1:0] frm_addr,
  input logic              cfg_done,
  input logic              cfg_err
);
  // R9
  done_hold_chk: assert property (@(posedge cclk) disable iff (!prog_n)
    cfg_done |=> cfg_done);

  // R7
  err_hold_chk: assert property (@(posedge cclk) disable iff (!prog_n)
    cfg_err |=> cfg_err);

  // R10
  dout_idle_chk: assert property (@(posedge cclk) disable iff (!prog_n)
    (cfg_done && $past(cfg_done)) |-> dout);

  // R10
  no_write_after_done_chk: assert property (@(posedge cclk) disable iff (!prog_n)
    (cfg_done && $past(cfg_done)) |-> !frm_we);

  // R11
  we_pulse_chk: assert property (@(posedge cclk) disable iff (!prog_n)
    frm_we |=> !frm_we);

  // R11
  addr_range_chk: assert property (@(posedge cclk) disable iff (!prog_n)
    frm_we |-> (int'(frm_addr) < NUM_FRAMES));
endmodule

bind cfg_chain_rx cfg_chain_rx_chk #(.ADDR_W(ADDR_W), .NUM_FRAMES(NUM_FRAMES)) u_chk (
  .cclk(cclk), .prog_n(prog_n), .dout(dout), .frm_we(frm_we),
  .frm_addr(frm_addr), .cfg_done(cfg_done), .cfg_err(cfg_err)
);

// File: tb/tb_cfg_chain_rx.sv
module tb_cfg_chain_rx;
  localparam int         PRE_W = 8;
  localparam logic [7:0] PRE   = 8'hB2;
  localparam int         LEN_W = 24;
  localparam int         FW    = 6;
  localparam int         NF    = 3;
  localparam int         AW    = 2;
  localparam int         PW    = FW - 2;

  logic          cclk = 1'b0;
  logic          prog_n = 1'b0;
  logic          din = 1'b1;
  logic          dout, frm_we, cfg_done, cfg_err;
  logic [AW-1:0] frm_addr;
  logic [PW-1:0] frm_data;

  int unsigned errs = 0;
  int unsigned checks = 0;
  bit          finished = 1'b0;
  logic        prev_exp = 1'b1;
  logic          we_s;
  logic [AW-1:0] addr_s;
  logic [PW-1:0] data_s;

  always #5 cclk = ~cclk;

  cfg_chain_rx #(.PRE_W(PRE_W), .PRE_VAL(PRE), .LEN_W(LEN_W), .FRAME_W(FW),
                 .NUM_FRAMES(NF)) dut (
    .cclk(cclk), .prog_n(prog_n), .din(din), .dout(dout), .frm_we(frm_we),
    .frm_addr(frm_addr), .frm_data(frm_data), .cfg_done(cfg_done), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one bit per cycle: drive, capture at rising edge, observe after falling edge
  task automatic step(input logic b, input logic exp_d, input string req);
    din = b;
    @(posedge cclk); #1;
    chk(dout === prev_exp, "R1", dout, prev_exp);
    we_s = frm_we; addr_s = frm_addr; data_s = frm_data;
    @(negedge cclk); #2;
    chk(dout === exp_d, req, dout, exp_d);
    prev_exp = exp_d;
  endtask

  task automatic do_reset();
    prog_n = 1'b0;
    din    = 1'b1;
    repeat (2) @(negedge cclk);
    #1;
    chk(dout === 1'b1, "R2", dout, 1);
    chk(cfg_done === 1'b0, "R2", cfg_done, 0);
    chk(cfg_err === 1'b0, "R2", cfg_err, 0);
    chk(frm_we === 1'b0, "R2", frm_we, 0);
    prog_n = 1'b1;
    repeat (3) @(negedge cclk);
    #2;
    prev_exp = 1'b1;
  endtask

  // bad < 0: all start pairs correct
  task automatic run(input int len, input int bad, input int seed);
    logic [LEN_W-1:0] lv;
    bit exp_err;
    lv = LEN_W'(len);
    exp_err = (bad >= 0) && (len >= bad * FW + 2);
    do_reset();
    step(1'b0, 1'b0, "R3");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, "R3");
    for (int i = PRE_W - 1; i >= 0; i--) step(PRE[i], PRE[i], "R3");
    chk(cfg_done === 1'b0, "R3", cfg_done, 0);
    for (int i = LEN_W - 1; i >= 0; i--) step(lv[i], lv[i], "R4");
    if (len == 0) chk(cfg_done === 1'b1, "R9", cfg_done, 1);
    for (int p = 0; p < len; p++) begin
      if (p < NF * FW) begin
        int fi = p / FW;
        int bi = p % FW;
        int pl = (fi * 11 + seed * 3 + 5) % (1 << PW);
        logic b;
        if (bi == 0)      b = (fi == bad);
        else if (bi == 1) b = 1'b1;
        else              b = pl[PW - 1 - (bi - 2)];
        step(b, 1'b1, "R5");
        if (bi == FW - 1) begin
          chk(we_s === 1'b1, "R6", we_s, 1);
          chk(addr_s === AW'(fi), "R6", addr_s, fi);
          chk(data_s === PW'(pl), "R6", data_s, pl);
        end else begin
          chk(we_s === 1'b0, "R6", we_s, 0);
        end
      end else begin
        logic b;
        b = ((p + seed) % 3) == 1;
        step(b, b, "R8");
        chk(we_s === 1'b0, "R8", we_s, 0);
      end
      if (p + 1 == len) chk(cfg_done === 1'b1, "R9", cfg_done, 1);
      else              chk(cfg_done === 1'b0, "R9", cfg_done, 0);
    end
    // new pattern and filler after done: no effect
    for (int i = PRE_W - 1; i >= 0; i--) begin
      step(PRE[i], 1'b1, "R10");
      chk(we_s === 1'b0, "R10", we_s, 0);
    end
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 1'b1, "R10");
      chk(we_s === 1'b0, "R10", we_s, 0);
      chk(cfg_done === 1'b1, "R10", cfg_done, 1);
    end
    chk(cfg_err === exp_err, "R7", cfg_err, exp_err);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    run(28, -1, 1);   // frames plus overflow, R8
    run(18, -1, 2);   // ends on last frame bit
    run(10, -1, 3);   // ends inside frame 1, R9
    run(0, -1, 4);    // zero length, R9
    run(20, 1, 5);    // bad start pair, R7
    run(24, -1, 6);   // clean after a bad run, R2 clears R7 flag
    for (int l = 16; l <= 23; l++)
      run(l, ((l % 2) == 1) ? (l % 3) : -1, l);
    run(3, 0, 7);     // bad pair, done right after it
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule